// File: doc/BRIEF.md
# Multi-Mode 16-bit Function Timer

This block is one channel of a general-purpose 16-bit timer. An up-counter advances on a prescaled clock enable and restarts from zero after it reaches a programmable period. Four operating modes share this counter. Plain timer mode raises period and duty interrupts only. Capture mode measures the period and high time of an input pulse. Dual-duty PWM mode drives two independent pulse-width outputs. Complementary mode drives one output and its inverse, with a programmable dead band between them.

Software writes a small register file. The period and duty writes are double-buffered so that a running waveform never glitches. The counter can also be started, stopped or cleared by the rising edge of an event input. An emergency-stop input parks both outputs at their inactive level and latches a flag that only software can clear. Each output has its own polarity select.

Top module: `ftmr16`

## Requirements
- R1: After reset the counter is stopped at 0, both outputs are low, all interrupt outputs are low and both capture results read 0.
- R2: While running, the counter advances by one on each cycle in which `tick` is high. On a tick where the count has reached the period, the count returns to 0 and `irq_period` is high for exactly the following cycle. The control register is at address 0, with mode in bits [1:0]. The command register is at address 1 and holds start (bit 0), stop (bit 1), emergency-flag clear (bit 2) and counter clear (bit 3).
- R3: With the one-shot bit (control bit 2) set, the counter stops at 0 after reaching the period. The outputs then fall inactive and do not restart without a new start.
- R4: In dual mode (mode 2), `out_a` is active while count < duty A (address 3) and `out_b` is active while count < duty B (address 4). In every mode except capture, `irq_duty` pulses for one cycle after a tick at which the count equals duty A.
- R5: The period (address 2) and duty writes land in buffers. While the counter runs, these buffers reach the comparators only at the period wrap. While it is stopped, they reach the comparators on the next clock.
- R6: In complementary mode (mode 3), `out_a` is active for count < duty A and `out_b` is active otherwise while running. Both are held inactive for D clock cycles, starting with the cycle in which the duty A comparison changes, where D is the dead-time register (address 5). The two outputs are never active together.
- R7: Control bits 3 and 4 invert `out_a` and `out_b` respectively. With a bit set, the pin is high when inactive.
- R8: A rising edge on `evt_in` starts the counter if control bit 5 is set, stops it if bit 6 is set, and clears it to 0 if bit 7 is set. When both are enabled, stop wins over start.
- R9: In capture mode (mode 1), each edge of `cap_in` is measured while the counter runs. A rising edge stores the count plus the current tick into `cap_period` and restarts the count from 0. A falling edge stores the same quantity into `cap_width`. Each such edge pulses `irq_cap` for one cycle. With a tick every cycle, these values equal the clock cycles since the last rising edge.
- R10: `estop_in` high stops the counter and latches an emergency flag, and `irq_estop` pulses once. While the flag is set, both outputs sit at their inactive level and start requests are ignored. The flag is cleared only by command bit 2, and clearing it does not restart the counter.
- R11: In timer mode (mode 0) and capture mode, both outputs stay at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| evt_in | input | 1 | Event trigger (rising edge acts) |
| cap_in | input | 1 | Capture input |
| estop_in | input | 1 | Emergency stop request |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| cap_period | output | 16 | Last measured period |
| cap_width | output | 16 | Last measured high time |
| irq_period | output | 1 | Period match pulse |
| irq_duty | output | 1 | Duty A match pulse |
| irq_cap | output | 1 | Capture edge pulse |
| irq_estop | output | 1 | Emergency stop pulse |

## Verification
The bench rewrites a duty value in the middle of a period. A design without double-buffering would change the output before the wrap. It follows a one-shot run past its period end, where a design that wraps would drive the outputs active again. In complementary mode it checks the dead band at both transitions, including the transition at the period wrap. An off-by-one counter there would shift the gap by a cycle.

The bench also issues a start while the emergency flag is latched and then clears the flag. A design that queued the start would begin toggling after the clear. It enables event start and event stop together, where the wrong priority leaves the counter running. In capture mode it checks the pulse widths, which expose a latch that misses the edge tick or fails to restart the count.

// File: rtl/ftmr16.sv
module ftmr16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         evt_in,
  input  logic         cap_in,
  input  logic         estop_in,
  output logic         out_a,
  output logic         out_b,
  output logic [W-1:0] cap_period,
  output logic [W-1:0] cap_width,
  output logic         irq_period,
  output logic         irq_duty,
  output logic         irq_cap,
  output logic         irq_estop
);
  localparam logic [2:0] A_CTRL = 3'd0, A_CMD = 3'd1, A_PER = 3'd2,
                         A_DA = 3'd3, A_DB = 3'd4, A_DEAD = 3'd5;
  localparam logic [W-1:0] ONE = 1;
  localparam logic [W-1:0] ZERO = '0;

  logic [7:0]   ctrl;
  logic [W-1:0] per_buf, da_buf, db_buf, per_act, da_act, db_act, dead, cnt, dt;
  logic         run, estop_flag, evt_prev, cap_prev, a_prev;

  wire [1:0] mode    = ctrl[1:0];
  wire       oneshot = ctrl[2];
  wire       pol_a   = ctrl[3];
  wire       pol_b   = ctrl[4];

  wire cmd       = wr_en && (wr_addr == A_CMD);
  wire evt_rise  = evt_in && !evt_prev;
  wire do_start  = (cmd && wr_data[0]) || (evt_rise && ctrl[5]);
  wire do_stop   = (cmd && wr_data[1]) || (evt_rise && ctrl[6]) || estop_in;
  wire do_clr    = (cmd && wr_data[3]) || (evt_rise && ctrl[7]);
  wire step      = tick && run;
  wire at_end    = step && (cnt >= per_act);
  wire capmode   = (mode == 2'd1);
  wire cap_rise  = run && capmode && cap_in && !cap_prev;
  wire cap_fall  = run && capmode && !cap_in && cap_prev;
  wire [W-1:0] cap_val = cnt + (tick ? ONE : ZERO);

  wire cmp_a = cnt < da_act;
  wire cmp_b = cnt < db_act;
  wire comp  = (mode == 2'd3);
  wire a_raw = run && mode[1] && cmp_a;
  wire edge_a = comp && (a_raw != a_prev);
  wire free  = edge_a ? (dead == ZERO) : (dt == ZERO);
  wire act_a = comp ? (a_raw && free) : a_raw;
  wire act_b = comp ? (run && !cmp_a && free) : (run && mode == 2'd2 && cmp_b);

  assign out_a = (act_a && !estop_flag) ^ pol_a;
  assign out_b = (act_b && !estop_flag) ^ pol_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; per_buf <= '0; da_buf <= '0; db_buf <= '0;
      per_act <= '0; da_act <= '0; db_act <= '0; dead <= '0;
      cnt <= '0; dt <= '0; run <= 1'b0; estop_flag <= 1'b0;
      evt_prev <= 1'b0; cap_prev <= 1'b0; a_prev <= 1'b0;
      cap_period <= '0; cap_width <= '0;
      irq_period <= 1'b0; irq_duty <= 1'b0; irq_cap <= 1'b0; irq_estop <= 1'b0;
    end else begin
      evt_prev <= evt_in;
      cap_prev <= cap_in;
      a_prev   <= a_raw;

      if (wr_en) begin
        case (wr_addr)
          A_CTRL:  ctrl    <= wr_data[7:0];
          A_PER:   per_buf <= wr_data;
          A_DA:    da_buf  <= wr_data;
          A_DB:    db_buf  <= wr_data;
          A_DEAD:  dead    <= wr_data;
          default: ;
        endcase
      end

      if (!run || at_end) begin
        per_act <= per_buf;
        da_act  <= da_buf;
        db_act  <= db_buf;
      end

      if (do_stop)                 run <= 1'b0;
      else if (at_end && oneshot)  run <= 1'b0;
      else if (do_start && !estop_flag) run <= 1'b1;

      if (do_clr || cap_rise || at_end) cnt <= '0;
      else if (step)                    cnt <= cnt + ONE;

      if (estop_in)                      estop_flag <= 1'b1;
      else if (cmd && wr_data[2])        estop_flag <= 1'b0;

      if (edge_a)            dt <= (dead == ZERO) ? ZERO : dead - ONE;
      else if (dt != ZERO)   dt <= dt - ONE;

      if (cap_rise) cap_period <= cap_val;
      if (cap_fall) cap_width  <= cap_val;

      irq_period <= at_end;
      irq_duty   <= step && !capmode && (cnt == da_act);
      irq_cap    <= cap_rise || cap_fall;
      irq_estop  <= estop_in && !estop_flag;
    end
  end
endmodule

module ftmr16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         oneshot,
  input logic         pol_a,
  input logic         pol_b,
  input logic         run,
  input logic [W-1:0] cnt,
  input logic         estop_flag,
  input logic         out_a,
  input logic         out_b,
  input logic         irq_period,
  input logic         irq_estop
);
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |-> (cnt == '0)); // R2
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_period && $past(oneshot)) |-> !run); // R3
  AST_COMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> !((out_a ^ pol_a) && (out_b ^ pol_b))); // R6
  AST_ESTOP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    estop_flag |-> (out_a == pol_a && out_b == pol_b)); // R10
  AST_ESTOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_estop |=> !irq_estop); // R10
  AST_IDLE_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 1'b0) |-> (out_a == pol_a && out_b == pol_b)); // R11
endmodule

bind ftmr16 ftmr16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(ctrl[1:0]), .oneshot(ctrl[2]),
  .pol_a(ctrl[3]), .pol_b(ctrl[4]), .run(run), .cnt(cnt),
  .estop_flag(estop_flag), .out_a(out_a), .out_b(out_b),
  .irq_period(irq_period), .irq_estop(irq_estop)
);

// File: tb/test_ftmr16.sv
module test_ftmr16;
  logic clk = 0, rst_n = 0, tick = 1, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic evt_in = 0, cap_in = 0, estop_in = 0;
  logic out_a, out_b, irq_period, irq_duty, irq_cap, irq_estop;
  logic [15:0] cap_period, cap_width;

  ftmr16 i_ftmr16 (.*);

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0, cs = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int qc[$];
  string qr[$];
  logic [5:0] qv[$];
  logic [5:0] obs;

  task automatic push(int c, string r, logic [5:0] v);
    qc.push_back(c); qr.push_back(r); qv.push_back(v);
  endtask

  always @(negedge clk) begin
    while (qc.size() > 0 && qc[0] == cyc) begin
      obs = {out_a, out_b, irq_period, irq_duty, irq_cap, irq_estop};
      checks++;
      if (obs !== qv[0]) begin
        fails++;
        $display("FAIL %s cycle %0d actual=%b expected=%b", qr[0], cyc, obs, qv[0]);
      end
      void'(qc.pop_front()); void'(qr.pop_front()); void'(qv.pop_front());
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_evt();
    @(negedge clk); evt_in = 1;
    @(negedge clk); evt_in = 0;
  endtask

  function automatic logic [5:0] dual(int k, int p, int da, int db);
    int c = k % (p + 1);
    int cp = (k - 1) % (p + 1);
    return {c < da, c < db, cp == p, cp == da, 2'b00};
  endfunction

  function automatic logic [5:0] compl(int k, logic pa);
    int c = k % 20;
    int cp = (k - 1) % 20;
    logic blk = (c < 3) || (c >= 10 && c < 13);
    return {((c < 10) && !blk) ^ pa, (c >= 10) && !blk, cp == 19, cp == 10, 2'b00};
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 outputs", {out_a, out_b, irq_period, irq_duty, irq_cap, irq_estop}, 0);
    chk("R1 capture", {cap_period, cap_width}, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 stopped", irq_period, 0);
    end

    // R2 R4 dual PWM, period 9, duties 3 and 6
    wr(0, 16'h0002); wr(2, 9); wr(3, 3); wr(4, 6);
    wr(1, 16'h0001); cs = cyc;
    for (int k = 1; k <= 26; k++) push(cs + k, "R2 R4 dual", dual(k, 9, 3, 6));
    idle(26);
    // R5 duty A rewritten mid-period, applies at the wrap (k=30)
    wr(3, 9);
    for (int k = 28; k <= 39; k++)
      push(cs + k, "R5 buffer", (k < 30) ? dual(k, 9, 3, 6) :
           {(k % 10) < 9, (k % 10) < 6, ((k - 1) % 10) == 9, 1'b0, 2'b00});
    idle(12);

    // R3 one-shot, period 4, duty A 2
    wr(1, 16'h0002);
    wr(0, 16'h0006); wr(2, 4); wr(3, 2); wr(4, 6);
    wr(1, 16'h0009); cs = cyc;
    for (int k = 1; k <= 10; k++)
      push(cs + k, "R3 oneshot", (k <= 4) ? {k < 2, 1'b1, 1'b0, k == 3, 2'b00} :
           {2'b00, k == 5, 3'b000});
    idle(10);

    // R6 complementary, period 19, duty A 10, dead 3
    wr(0, 16'h0003); wr(2, 19); wr(3, 10); wr(5, 3);
    wr(1, 16'h0009); cs = cyc;
    for (int k = 1; k <= 40; k++) push(cs + k, "R6 comp", compl(k, 1'b0));
    idle(40);
    // R7 invert output A while running
    wr(0, 16'h000B);
    for (int k = 42; k <= 60; k++) push(cs + k, "R7 polarity", compl(k, 1'b1));
    idle(19);

    // R10 emergency stop
    @(negedge clk); estop_in = 1;
    @(negedge clk); estop_in = 0;
    chk("R10 irq", irq_estop, 1);
    chk("R10 safe", {out_a, out_b}, 2'b10);
    @(negedge clk);
    chk("R10 single pulse", irq_estop, 0);
    wr(1, 16'h0001);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R10 start ignored", {out_a, out_b}, 2'b10);
    end
    wr(1, 16'h0004);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R10 no restart", {out_a, out_b}, 2'b10);
    end
    wr(1, 16'h0009); cs = cyc;
    for (int k = 1; k <= 20; k++) push(cs + k, "R10 resume", compl(k, 1'b1));
    idle(20);

    // R8 events
    wr(1, 16'h000A);
    wr(0, 16'h0022); wr(2, 7); wr(3, 4); wr(4, 2);
    pulse_evt(); cs = cyc;
    for (int k = 1; k <= 16; k++) push(cs + k, "R8 event start", dual(k, 7, 4, 2));
    idle(16);
    wr(0, 16'h00C2);
    pulse_evt();
    chk("R8 event stop", {out_a, out_b}, 0);
    wr(1, 16'h0001); cs = cyc;
    for (int k = 1; k <= 8; k++) push(cs + k, "R8 event clear", dual(k, 7, 4, 2));
    idle(8);
    wr(0, 16'h0062);
    pulse_evt();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R8 stop wins", {out_a, out_b}, 0);
    end

    // R9 R11 capture
    wr(1, 16'h000A);
    wr(0, 16'h0001); wr(2, 16'hFFFF);
    wr(1, 16'h0001);
    idle(4); cap_in = 1;
    @(negedge clk);
    chk("R9 rise irq", irq_cap, 1);
    chk("R9 period 1", cap_period, 5);
    chk("R11 outputs idle", {out_a, out_b}, 0);
    idle(5); cap_in = 0;
    @(negedge clk);
    chk("R9 fall irq", irq_cap, 1);
    chk("R9 width", cap_width, 6);
    @(negedge clk);
    chk("R9 irq pulse", irq_cap, 0);
    idle(8); cap_in = 1;
    @(negedge clk);
    chk("R9 period 2", cap_period, 16);
    chk("R9 irq 2", irq_cap, 1);
    idle(3);
    finish_run();
  end
endmodule